// File: doc/BRIEF.md
# Addressed Threshold Comparator Controller

This block serves one sensor. It holds a device address and an unsigned reference value. It answers every sensor sample with a two-word report that tells a control panel whether the controlled quantity should go down, go up or stay as it is. The device address and the starting reference are fixed by parameters at instantiation.

A configuration word stream can change the reference at run time. The stream carries pairs of words: an address word, then a value word. Only a pair whose address equals the controller's own address rewrites the reference. Pairs sent to other addresses pass by and leave it unchanged.

Every stream uses a valid/ready handshake. The configuration input is always ready. The sample input takes a new sample only when no report is still in flight. The report output keeps each word steady until the panel accepts it.

Top module: `addr_thresh_ctrl`

## Requirements
- R1: After reset, the reference equals the INIT_REF parameter (default 25). The report output is not valid, and both the sample input and the configuration input are ready.
- R2: The configuration stream is a sequence of word pairs. The first accepted word of a pair is an address and the second is a value. Idle cycles between the two words do not break the pairing, and a value word is never read as an address.
- R3: When the address word of a pair equals OWN_ADDR, the value word of that pair becomes the new reference.
- R4: When the address word of a pair differs from OWN_ADDR, the reference keeps its previous value.
- R5: A sample greater than the reference yields the command code 2 (lower).
- R6: A sample less than the reference yields the command code 1 (raise).
- R7: A sample equal to the reference yields the command code 0 (hold).
- R8: Each report has two words. The first word is OWN_ADDR. The second word carries the command code in bits 1:0, with all higher bits zero. While the panel withholds ready, the current word stays valid and unchanged.
- R9: Once a sample is accepted, the sample input stays not ready until the command word of its report has been transferred.
- R10: A value word and a sample may be accepted in the same cycle. If the value word belongs to a pair addressed to this controller, the sample is compared against the new value.
- R11: Samples and the reference are compared as unsigned 16-bit numbers, so 0x8000 is greater than 25.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration word is valid |
| cfg_ready | output | 1 | Configuration input is ready (always high) |
| cfg_data | input | 16 | Configuration word (address or value) |
| smp_valid | input | 1 | Sample is valid |
| smp_ready | output | 1 | Sample input is ready |
| smp_data | input | 16 | Unsigned sensor sample |
| rpt_valid | output | 1 | Report word is valid |
| rpt_ready | input | 1 | Panel accepts the report word |
| rpt_data | output | 16 | Report word: own address, then command |

## Verification
The reference update and the sample comparison can land on the same clock edge. This happens when the value word of a configuration pair and a sample are both accepted together. The bench sets this up by presenting the address word one cycle early, then driving the value word and the sample in the same cycle. It chooses the old and new references so that comparing against the stale value would give a different command code. It repeats the collision with a pair aimed at another address, where the old reference must still decide the outcome.

// File: rtl/atc_pkg.sv
package atc_pkg;

  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_RAISE = 2'd1,
    CMD_LOWER = 2'd2
  } atc_cmd_e;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_ADDR = 2'd1,
    RS_CMD  = 2'd2
  } atc_rpt_state_e;

endpackage

// File: rtl/atc_cfg_port.sv
module atc_cfg_port #(
  parameter int unsigned       W        = 16,
  parameter logic [W-1:0]      OWN_ADDR = 16'h0005,
  parameter logic [W-1:0]      INIT_REF = 16'd25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_valid,
  input  logic [W-1:0] cfg_data,
  output logic [W-1:0] ref_eff
);

  logic         want_val_q, want_val_d;
  logic         hit_q, hit_d;
  logic [W-1:0] ref_q, ref_d;
  logic         ref_load;

  assign ref_load = cfg_valid && want_val_q && hit_q;
  // forward a same-cycle update to the comparator
  assign ref_eff  = ref_load ? cfg_data : ref_q;

  always_comb begin
    want_val_d = want_val_q;
    hit_d      = hit_q;
    ref_d      = ref_q;
    if (cfg_valid) begin
      want_val_d = !want_val_q;
      if (!want_val_q) begin
        hit_d = (cfg_data == OWN_ADDR);
      end
    end
    if (ref_load) begin
      ref_d = cfg_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_val_q <= 1'b0;
      hit_q      <= 1'b0;
      ref_q      <= INIT_REF;
    end else begin
      if (cfg_valid) begin
        want_val_q <= want_val_d;
        hit_q      <= hit_d;
      end
      if (ref_load) begin
        ref_q <= ref_d;
      end
    end
  end

  a_r2_pair_phase: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> (want_val_q != $past(want_val_q)));

  a_r3_ref_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && want_val_q && hit_q) |=> (ref_q == $past(cfg_data)));

  a_r4_ref_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && want_val_q && !hit_q) |=> $stable(ref_q));

endmodule

// File: rtl/atc_compare.sv
module atc_compare
  import atc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] sample,
  input  logic [W-1:0] ref_val,
  output atc_cmd_e     cmd
);

  always_comb begin
    if (sample > ref_val) begin
      cmd = CMD_LOWER;
    end else if (sample < ref_val) begin
      cmd = CMD_RAISE;
    end else begin
      cmd = CMD_HOLD;
    end
  end

endmodule

// File: rtl/atc_rpt_engine.sv
module atc_rpt_engine
  import atc_pkg::*;
#(
  parameter int unsigned  W        = 16,
  parameter logic [W-1:0] OWN_ADDR = 16'h0005
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_valid,
  input  atc_cmd_e     cmd_in,
  output logic         smp_ready,
  output logic         rpt_valid,
  input  logic         rpt_ready,
  output logic [W-1:0] rpt_data
);

  localparam int unsigned PAD_W = W - $bits(atc_cmd_e);

  atc_rpt_state_e state_q, state_d;
  atc_cmd_e       cmd_q;
  logic           smp_fire;

  assign smp_ready = (state_q == RS_IDLE);
  assign smp_fire  = smp_valid && smp_ready;
  assign rpt_valid = (state_q != RS_IDLE);
  assign rpt_data  = (state_q == RS_ADDR) ? OWN_ADDR : {{PAD_W{1'b0}}, cmd_q};

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RS_IDLE: if (smp_valid) state_d = RS_ADDR;
      RS_ADDR: if (rpt_ready) state_d = RS_CMD;
      RS_CMD:  if (rpt_ready) state_d = RS_IDLE;
      default: state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      cmd_q   <= CMD_HOLD;
    end else begin
      state_q <= state_d;
      if (smp_fire) begin
        cmd_q <= cmd_in;
      end
    end
  end

  a_r8_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !rpt_ready) |=> (rpt_valid && $stable(rpt_data)));

  a_r8_cmd_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && rpt_ready && state_q == RS_ADDR) |=> (rpt_valid && rpt_data < 3));

  a_r9_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    smp_fire |=> !smp_ready);

  a_r7_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_fire && cmd_in == CMD_HOLD) |=> (cmd_q == CMD_HOLD));

endmodule

// File: rtl/addr_thresh_ctrl.sv
module addr_thresh_ctrl
  import atc_pkg::*;
#(
  parameter int unsigned  W        = 16,
  parameter logic [W-1:0] OWN_ADDR = 16'h0005,
  parameter logic [W-1:0] INIT_REF = 16'd25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_valid,
  output logic         cfg_ready,
  input  logic [W-1:0] cfg_data,
  input  logic         smp_valid,
  output logic         smp_ready,
  input  logic [W-1:0] smp_data,
  output logic         rpt_valid,
  input  logic         rpt_ready,
  output logic [W-1:0] rpt_data
);

  logic [W-1:0] ref_eff;
  atc_cmd_e     cmd;

  assign cfg_ready = 1'b1;

  atc_cfg_port #(.W(W), .OWN_ADDR(OWN_ADDR), .INIT_REF(INIT_REF)) i_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_data  (cfg_data),
    .ref_eff   (ref_eff)
  );

  atc_compare #(.W(W)) i_cmp (
    .sample  (smp_data),
    .ref_val (ref_eff),
    .cmd     (cmd)
  );

  atc_rpt_engine #(.W(W), .OWN_ADDR(OWN_ADDR)) i_rpt (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .cmd_in    (cmd),
    .smp_ready (smp_ready),
    .rpt_valid (rpt_valid),
    .rpt_ready (rpt_ready),
    .rpt_data  (rpt_data)
  );

  a_r8_first_word_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> (rpt_valid && rpt_data == OWN_ADDR));

  a_r1_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !rpt_valid |-> smp_ready);

endmodule

// File: tb/test_addr_thresh_ctrl.sv
module test_addr_thresh_ctrl;

  localparam logic [15:0] OWN = 16'h0005;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_valid, cfg_ready;
  logic [15:0] cfg_data;
  logic        smp_valid, smp_ready;
  logic [15:0] smp_data;
  logic        rpt_valid, rpt_ready;
  logic [15:0] rpt_data;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  addr_thresh_ctrl #(.W(16), .OWN_ADDR(OWN), .INIT_REF(16'd25)) i_addr_thresh_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_data(rpt_data)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic collect(input logic [15:0] exp_cmd, input int stall, input string req);
    for (int i = 0; i < stall; i++) begin
      check(rpt_valid && rpt_data == OWN, "R8 address word held", rpt_data, OWN);
      check(!smp_ready, "R9 busy while stalled", {15'd0, smp_ready}, 16'd0);
      @(negedge clk);
    end
    rpt_ready = 1'b1;
    check(rpt_valid && rpt_data == OWN, "R8 first word is address", rpt_data, OWN);
    @(negedge clk);
    check(rpt_valid && rpt_data == exp_cmd, req, rpt_data, exp_cmd);
    check(!smp_ready, "R9 busy until command word sent", {15'd0, smp_ready}, 16'd0);
    @(negedge clk);
    rpt_ready = 1'b0;
    check(!rpt_valid && smp_ready, "R9 ready after report", {14'd0, rpt_valid, smp_ready}, 16'h0001);
  endtask

  task automatic do_sample(input logic [15:0] v, input logic [15:0] exp_cmd, input int stall, input string req);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = v;
    while (!smp_ready) @(negedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
    collect(exp_cmd, stall, req);
  endtask

  task automatic send_cfg(input logic [15:0] a, input logic [15:0] v, input int gap);
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_data  = a;
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      cfg_valid = 1'b0;
      cfg_data  = 16'hFFFF;
    end
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_data  = v;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic t_reset;
    check(!rpt_valid, "R1 report idle", {15'd0, rpt_valid}, 16'd0);
    check(smp_ready, "R1 sample ready", {15'd0, smp_ready}, 16'd1);
    check(cfg_ready, "R1 config ready", {15'd0, cfg_ready}, 16'd1);
  endtask

  task automatic t_initial_ref;
    do_sample(16'd30, 16'd2, 0, "R5 above initial reference");
    do_sample(16'd10, 16'd1, 0, "R6 below initial reference");
    do_sample(16'd25, 16'd0, 0, "R7 R1 equals initial 25");
  endtask

  task automatic t_unsigned;
    do_sample(16'h8000, 16'd2, 0, "R11 0x8000 above 25");
    do_sample(16'h0000, 16'd1, 0, "R11 zero below 25");
  endtask

  task automatic t_cfg_match;
    send_cfg(OWN, 16'd100, 0);
    do_sample(16'd100, 16'd0, 0, "R3 new reference 100");
    do_sample(16'd101, 16'd2, 0, "R3 above new reference");
  endtask

  task automatic t_cfg_other;
    send_cfg(16'h0006, 16'd7, 0);
    do_sample(16'd100, 16'd0, 0, "R4 foreign address ignored");
    send_cfg(16'h0009, OWN, 0);
    send_cfg(OWN, 16'd50, 2);
    do_sample(16'd50, 16'd0, 0, "R2 pairing across gap and value=own");
    do_sample(16'd49, 16'd1, 0, "R2 R6 below 50");
  endtask

  task automatic t_stall;
    do_sample(16'd60, 16'd2, 3, "R8 command after stall");
    do_sample(16'd50, 16'd0, 2, "R8 hold after stall");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cfg_valid = 1'b1; cfg_data = OWN;
    @(negedge clk);
    cfg_data = 16'd60; smp_valid = 1'b1; smp_data = 16'd60;
    @(negedge clk);
    cfg_valid = 1'b0; smp_valid = 1'b0;
    collect(16'd0, 0, "R10 sample sees new reference 60");
    @(negedge clk);
    cfg_valid = 1'b1; cfg_data = 16'h0003;
    @(negedge clk);
    cfg_data = 16'd10; smp_valid = 1'b1; smp_data = 16'd60;
    @(negedge clk);
    cfg_valid = 1'b0; smp_valid = 1'b0;
    collect(16'd0, 0, "R10 R4 foreign pair keeps 60");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_valid = 1'b0; cfg_data = 16'd0;
    smp_valid = 1'b0; smp_data = 16'd0;
    rpt_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_initial_ref();
    t_unsigned();
    t_cfg_match();
    t_cfg_other();
    t_stall();
    t_same_cycle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule